// File: doc/BRIEF.md
# Synchronising Register File with Sleep-Wakeup States

This block is a register file for a processor that interleaves many lightweight threads, each of which is nothing more than a program counter. Every register carries a two-bit synchronisation state: empty, full or waiting. A read at the register-read stage has one of three outcomes. A full register returns its data, and the reader is told to send its thread back to the ready queue. An empty register takes the reader's PC into its own data field and becomes waiting, so the thread sleeps inside the register it needs. A waiting register already holds a sleeper, so the read is refused with an error.

A sleeping thread is woken in one of two ways. A data write to the waiting register stores the data and makes it full. A set command makes it full with data zero, which is how a finishing thread signals its parent. In both cases the parked PC is sent out for one cycle on one of two wake lanes: lane 0 for writes and lane 1 for sets. A per-register clear and a clear-all return registers to empty for the next round of synchronisation.

Top module: `srf_sync_regfile`

## Requirements
- R1: After the asynchronous reset, every register other than register 0 is empty, and no wake lane is valid.
- R2: A read of an empty register reports park. On the next edge the register becomes waiting and holds the reader's PC, zero-extended, in its data field.
- R3: A read of a full register reports ok and returns the register data in the same cycle.
- R4: A write to a register other than 0 makes it full with the written data. If it was waiting, wake lane 0 is valid in the following cycle, for exactly one cycle, and carries the parked PC.
- R5: A set on a register other than 0 makes it full with data zero. If it was waiting, wake lane 1 pulses with the parked PC in the following cycle. A set aimed at the register written in the same cycle is ignored.
- R6: A clear makes one register empty. Any parked PC is dropped without a wake.
- R7: A read of a waiting register reports err. The register, its state and its parked PC are left unchanged.
- R8: Reads see the write and the set of the same cycle. When both ports read the same empty register in one cycle, port 0 parks and port 1 reports err.
- R9: Register 0 always reads ok with value zero. Writes, sets and clears aimed at it have no effect.
- R10: Clear and clear-all take effect after the same cycle's write, set and park. A wake caused by that cycle's write or set is still issued, and clear-all makes every register other than 0 empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_en | input | 1 | Read port 0 request |
| rd0_addr | input | AW | Read port 0 register index |
| rd0_pc | input | PCW | PC of the thread reading on port 0 |
| rd0_ok | output | 1 | Port 0 data valid; the thread returns to the ready queue |
| rd0_park | output | 1 | Port 0 thread parked in the register |
| rd0_err | output | 1 | Port 0 register already has a sleeper |
| rd0_data | output | DW | Port 0 data, zero unless ok |
| rd1_en | input | 1 | Read port 1 request |
| rd1_addr | input | AW | Read port 1 register index |
| rd1_pc | input | PCW | PC of the thread reading on port 1 |
| rd1_ok | output | 1 | Port 1 data valid |
| rd1_park | output | 1 | Port 1 thread parked |
| rd1_err | output | 1 | Port 1 register already has a sleeper |
| rd1_data | output | DW | Port 1 data, zero unless ok |
| wr_en | input | 1 | Data write request |
| wr_addr | input | AW | Write register index |
| wr_data | input | DW | Write data |
| sig_en | input | 1 | Set (completion signal) request |
| sig_addr | input | AW | Set register index |
| clr_en | input | 1 | Single-register clear request |
| clr_addr | input | AW | Clear register index |
| clr_all | input | 1 | Clear every register |
| wake_vld | output | 2 | Wake lane valid: bit 0 from writes, bit 1 from sets |
| wake_pc0 | output | PCW | PC released on lane 0 |
| wake_pc1 | output | PCW | PC released on lane 1 |

## Verification
The assertions assume that rd0_pc and rd1_pc fit in PCW bits and that every address lies below NREG. They also assume the inputs are stable around the clock edge. The random stimulus keeps all addresses inside the first eight registers, so reads, writes, sets and clears collide often. Clears and clear-all are made rare so that waiting registers can build up before they are woken. Directed steps cover the same-cycle cases: a double read of one register, a write forwarded to a read, and a clear that lands with a park.

// File: rtl/srf_pkg.sv
package srf_pkg;
  // synchronisation state codes carried beside each data word
  localparam logic [1:0] ST_EMPTY = 2'b00;
  localparam logic [1:0] ST_FULL  = 2'b01;
  localparam logic [1:0] ST_WAIT  = 2'b10;
endpackage

// File: rtl/srf_entry.sv
module srf_entry
  import srf_pkg::*;
#(
  parameter int DW  = 32,
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  input  logic           set_en,
  input  logic           park_en,
  input  logic [PCW-1:0] park_pc,
  input  logic           clr_en,
  output logic [1:0]     st_o,
  output logic [DW-1:0]  data_o
);
  logic [1:0]    st_q, st_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          st_ce, dat_ce;

  always_comb begin
    st_d   = st_q;
    dat_d  = dat_q;
    dat_ce = 1'b0;
    if (wr_en) begin
      st_d   = ST_FULL;
      dat_d  = wr_data;
      dat_ce = 1'b1;
    end else if (set_en) begin
      st_d   = ST_FULL;
      dat_d  = '0;
      dat_ce = 1'b1;
    end else if (park_en) begin
      st_d   = ST_WAIT;
      dat_d  = DW'(park_pc);
      dat_ce = 1'b1;
    end
    if (clr_en) begin
      st_d = ST_EMPTY;
    end
    st_ce = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_EMPTY;
    end else if (st_ce) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dat_ce) begin
      dat_q <= dat_d;
    end
  end

  assign st_o   = st_q;
  assign data_o = dat_q;

  // R7: a sleeper is kept until a write, set or clear reaches this entry
  a_r7_sleeper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !wr_en && !set_en && !clr_en)
      |=> (st_q == ST_WAIT && $stable(dat_q)));

  // R6: a clear always leaves the entry empty
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (st_q == ST_EMPTY));
endmodule

// File: rtl/srf_read_port.sv
module srf_read_port
  import srf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [AW-1:0]            addr,
  input  logic [NREG-1:0][1:0]     st_all,
  input  logic [NREG-1:0][DW-1:0]  dat_all,
  input  logic                     fw_wr,
  input  logic [AW-1:0]            fw_wr_addr,
  input  logic [DW-1:0]            fw_wr_data,
  input  logic                     fw_set,
  input  logic [AW-1:0]            fw_set_addr,
  input  logic                     prior_park,
  input  logic [AW-1:0]            prior_addr,
  output logic                     ok,
  output logic                     park,
  output logic                     err,
  output logic [DW-1:0]            data
);
  logic [1:0]    v_st;
  logic [DW-1:0] v_dat;

  // effective view of the addressed register at the read stage
  always_comb begin
    v_st  = st_all[addr];
    v_dat = dat_all[addr];
    if (addr == '0) begin
      v_st  = ST_FULL;
      v_dat = '0;
    end else if (fw_wr && fw_wr_addr == addr) begin
      v_st  = ST_FULL;
      v_dat = fw_wr_data;
    end else if (fw_set && fw_set_addr == addr) begin
      v_st  = ST_FULL;
      v_dat = '0;
    end else if (prior_park && prior_addr == addr) begin
      v_st  = ST_WAIT;
    end
  end

  assign ok   = en && (v_st == ST_FULL);
  assign park = en && (v_st == ST_EMPTY);
  assign err  = en && (v_st == ST_WAIT);
  assign data = ok ? v_dat : '0;

  // R9: register 0 is always full and zero
  a_r9_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (en && addr == '0) |-> (ok && data == '0));

  // R3: one outcome per read
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $onehot({ok, park, err}));
endmodule

// File: rtl/srf_wake.sv
module srf_wake
  import srf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int PCW  = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0][1:0]     st_all,
  input  logic [NREG-1:0][PCW-1:0] pc_all,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic                     sig_en,
  input  logic [AW-1:0]            sig_addr,
  output logic [1:0]               wake_vld,
  output logic [PCW-1:0]           wake_pc0,
  output logic [PCW-1:0]           wake_pc1
);
  logic [1:0]     vld_d;
  logic [PCW-1:0] pc0_q, pc1_q;

  always_comb begin
    vld_d[0] = wr_en && (wr_addr != '0) && (st_all[wr_addr] == ST_WAIT);
    vld_d[1] = sig_en && (sig_addr != '0) && !(wr_en && wr_addr == sig_addr)
               && (st_all[sig_addr] == ST_WAIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_vld <= '0;
    end else begin
      wake_vld <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_d[0]) pc0_q <= pc_all[wr_addr];
    if (vld_d[1]) pc1_q <= pc_all[sig_addr];
  end

  assign wake_pc0 = pc0_q;
  assign wake_pc1 = pc1_q;

  // R4: a wake pulse lasts one cycle unless a new release follows
  a_r4_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_vld[0] && !vld_d[0]) |=> !wake_vld[0]);
endmodule

// File: rtl/srf_sync_regfile.sv
module srf_sync_regfile
  import srf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int PCW  = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd0_en,
  input  logic [AW-1:0]  rd0_addr,
  input  logic [PCW-1:0] rd0_pc,
  output logic           rd0_ok,
  output logic           rd0_park,
  output logic           rd0_err,
  output logic [DW-1:0]  rd0_data,
  input  logic           rd1_en,
  input  logic [AW-1:0]  rd1_addr,
  input  logic [PCW-1:0] rd1_pc,
  output logic           rd1_ok,
  output logic           rd1_park,
  output logic           rd1_err,
  output logic [DW-1:0]  rd1_data,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           sig_en,
  input  logic [AW-1:0]  sig_addr,
  input  logic           clr_en,
  input  logic [AW-1:0]  clr_addr,
  input  logic           clr_all,
  output logic [1:0]     wake_vld,
  output logic [PCW-1:0] wake_pc0,
  output logic [PCW-1:0] wake_pc1
);
  logic [NREG-1:0][1:0]     st_all;
  logic [NREG-1:0][DW-1:0]  dat_all;
  logic [NREG-1:0][PCW-1:0] pc_all;
  logic [NREG-1:1]          busy;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign st_all[g]  = ST_FULL;
      assign dat_all[g] = '0;
    end else begin : g_live
      logic wr_hit, set_hit, park_hit, clr_hit;
      logic [PCW-1:0] park_pc;
      assign wr_hit   = wr_en && (wr_addr == AW'(g));
      assign set_hit  = sig_en && (sig_addr == AW'(g));
      assign clr_hit  = clr_all || (clr_en && clr_addr == AW'(g));
      assign park_hit = (rd0_park && rd0_addr == AW'(g)) ||
                        (rd1_park && rd1_addr == AW'(g));
      assign park_pc  = (rd0_park && rd0_addr == AW'(g)) ? rd0_pc : rd1_pc;
      srf_entry #(.DW(DW), .PCW(PCW)) u_entry (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_hit), .wr_data(wr_data),
        .set_en(set_hit),
        .park_en(park_hit), .park_pc(park_pc),
        .clr_en(clr_hit),
        .st_o(st_all[g]), .data_o(dat_all[g])
      );
      assign busy[g] = (st_all[g] != ST_EMPTY);
    end
    assign pc_all[g] = dat_all[g][PCW-1:0];
  end

  srf_read_port #(.NREG(NREG), .DW(DW)) u_rp0 (
    .clk(clk), .rst_n(rst_n),
    .en(rd0_en), .addr(rd0_addr),
    .st_all(st_all), .dat_all(dat_all),
    .fw_wr(wr_en), .fw_wr_addr(wr_addr), .fw_wr_data(wr_data),
    .fw_set(sig_en), .fw_set_addr(sig_addr),
    .prior_park(1'b0), .prior_addr('0),
    .ok(rd0_ok), .park(rd0_park), .err(rd0_err), .data(rd0_data)
  );

  srf_read_port #(.NREG(NREG), .DW(DW)) u_rp1 (
    .clk(clk), .rst_n(rst_n),
    .en(rd1_en), .addr(rd1_addr),
    .st_all(st_all), .dat_all(dat_all),
    .fw_wr(wr_en), .fw_wr_addr(wr_addr), .fw_wr_data(wr_data),
    .fw_set(sig_en), .fw_set_addr(sig_addr),
    .prior_park(rd0_park), .prior_addr(rd0_addr),
    .ok(rd1_ok), .park(rd1_park), .err(rd1_err), .data(rd1_data)
  );

  srf_wake #(.NREG(NREG), .PCW(PCW)) u_wake (
    .clk(clk), .rst_n(rst_n),
    .st_all(st_all), .pc_all(pc_all),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .sig_en(sig_en), .sig_addr(sig_addr),
    .wake_vld(wake_vld), .wake_pc0(wake_pc0), .wake_pc1(wake_pc1)
  );

  // R8: two ports never park the same register
  a_r8_one_sleeper: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd0_park && rd1_park && rd0_addr == rd1_addr));

  // R2: a park on port 0 lands in the register unless cleared
  a_r2_park_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_park && !clr_all && !(clr_en && clr_addr == rd0_addr))
      |=> (st_all[$past(rd0_addr)] == ST_WAIT &&
           pc_all[$past(rd0_addr)] == $past(rd0_pc)));

  // R10: clear-all empties every live register
  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (busy == '0));

  // R4: a write to a sleeper releases its PC on lane 0
  a_r4_write_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && st_all[wr_addr] == ST_WAIT)
      |=> (wake_vld[0] && wake_pc0 == $past(pc_all[wr_addr])));

  // R5: a set leaves the register full with zero data
  a_r5_set_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_en && sig_addr != '0 && !clr_all && !(clr_en && clr_addr == sig_addr)
     && !(wr_en && wr_addr == sig_addr))
      |=> (st_all[$past(sig_addr)] == ST_FULL && dat_all[$past(sig_addr)] == '0));
endmodule

// File: tb/test_srf_sync_regfile.sv
module test_srf_sync_regfile;
  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int PCW  = 16;
  localparam int AW   = $clog2(NREG);
  localparam int E = 0, F = 1, W = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic rd0_en, rd1_en, wr_en, sig_en, clr_en, clr_all;
  logic [AW-1:0] rd0_addr, rd1_addr, wr_addr, sig_addr, clr_addr;
  logic [PCW-1:0] rd0_pc, rd1_pc;
  logic [DW-1:0] wr_data;
  logic rd0_ok, rd0_park, rd0_err, rd1_ok, rd1_park, rd1_err;
  logic [DW-1:0] rd0_data, rd1_data;
  logic [1:0] wake_vld;
  logic [PCW-1:0] wake_pc0, wake_pc1;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string tag = "";

  int m_st [NREG];
  logic [DW-1:0] m_dat [NREG];
  logic [1:0] x_wv;
  logic [PCW-1:0] x_pc0, x_pc1;

  always #5 clk = ~clk;

  srf_sync_regfile #(.NREG(NREG), .DW(DW), .PCW(PCW)) i_srf_sync_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_pc(rd0_pc),
    .rd0_ok(rd0_ok), .rd0_park(rd0_park), .rd0_err(rd0_err), .rd0_data(rd0_data),
    .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_pc(rd1_pc),
    .rd1_ok(rd1_ok), .rd1_park(rd1_park), .rd1_err(rd1_err), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sig_en(sig_en), .sig_addr(sig_addr),
    .clr_en(clr_en), .clr_addr(clr_addr), .clr_all(clr_all),
    .wake_vld(wake_vld), .wake_pc0(wake_pc0), .wake_pc1(wake_pc1)
  );

  task automatic chk(input bit cond, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_view(input int a, input bit usep, input int pa,
                                     output int st, output logic [DW-1:0] d);
    d = '0;
    if (a == 0) st = F;
    else if (wr_en && int'(wr_addr) == a) begin st = F; d = wr_data; end
    else if (sig_en && int'(sig_addr) == a) st = F;
    else if (usep && pa == a) st = W;
    else begin st = m_st[a]; d = m_dat[a]; end
  endfunction

  function automatic string req_of(input int st, input int a);
    if (tag != "") return tag;
    if (st == E) return "R2";
    if (st == W) return "R7";
    return (a == 0) ? "R9" : "R3";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) begin m_st[i] = E; m_dat[i] = '0; end
    m_st[0] = F;
    x_wv = '0; x_pc0 = '0; x_pc1 = '0;
  endtask

  // evaluate one cycle: inputs already driven after the falling edge
  task automatic eval();
    int s0, s1;
    logic [DW-1:0] d0, d1;
    bit p0, p1, w0, w1;
    #1;
    // wake lanes reflect the previous cycle
    chk(wake_vld[0] == x_wv[0] && (!x_wv[0] || wake_pc0 == x_pc0), "R4 wake lane0",
        {wake_vld[0], wake_pc0}, {x_wv[0], x_pc0});
    chk(wake_vld[1] == x_wv[1] && (!x_wv[1] || wake_pc1 == x_pc1), "R5 wake lane1",
        {wake_vld[1], wake_pc1}, {x_wv[1], x_pc1});
    p0 = 0; p1 = 0;
    if (rd0_en) begin
      model_view(int'(rd0_addr), 0, 0, s0, d0);
      chk(rd0_ok == (s0 == F) && rd0_park == (s0 == E) && rd0_err == (s0 == W)
          && (s0 != F || rd0_data == d0), {req_of(s0, int'(rd0_addr)), " port0"},
          {rd0_ok, rd0_park, rd0_err, rd0_data}, {s0 == F, s0 == E, s0 == W, d0});
      p0 = (s0 == E);
    end
    if (rd1_en) begin
      model_view(int'(rd1_addr), p0, int'(rd0_addr), s1, d1);
      chk(rd1_ok == (s1 == F) && rd1_park == (s1 == E) && rd1_err == (s1 == W)
          && (s1 != F || rd1_data == d1), {req_of(s1, int'(rd1_addr)), " port1"},
          {rd1_ok, rd1_park, rd1_err, rd1_data}, {s1 == F, s1 == E, s1 == W, d1});
      p1 = (s1 == E);
    end
    // next wake expectation
    w0 = wr_en && wr_addr != 0 && m_st[wr_addr] == W;
    w1 = sig_en && sig_addr != 0 && !(wr_en && wr_addr == sig_addr) && m_st[sig_addr] == W;
    x_wv = {w1, w0};
    if (w0) x_pc0 = m_dat[wr_addr][PCW-1:0];
    if (w1) x_pc1 = m_dat[sig_addr][PCW-1:0];
    // next register state: write, set, park, then clears
    if (wr_en && wr_addr != 0) begin m_st[wr_addr] = F; m_dat[wr_addr] = wr_data; end
    if (sig_en && sig_addr != 0 && !(wr_en && wr_addr == sig_addr)) begin
      m_st[sig_addr] = F; m_dat[sig_addr] = '0;
    end
    if (p0) begin m_st[rd0_addr] = W; m_dat[rd0_addr] = DW'(rd0_pc); end
    if (p1) begin m_st[rd1_addr] = W; m_dat[rd1_addr] = DW'(rd1_pc); end
    if (clr_en && clr_addr != 0) m_st[clr_addr] = E;
    if (clr_all) for (int i = 1; i < NREG; i++) m_st[i] = E;
  endtask

  task automatic idle();
    rd0_en = 0; rd1_en = 0; wr_en = 0; sig_en = 0; clr_en = 0; clr_all = 0;
    rd0_addr = '0; rd1_addr = '0; wr_addr = '0; sig_addr = '0; clr_addr = '0;
    rd0_pc = '0; rd1_pc = '0; wr_data = '0;
  endtask

  task automatic step_begin();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: after reset a register is empty and parks the reader
    step_begin(); tag = "R1";
    rd0_en = 1; rd0_addr = 3; rd0_pc = 16'h0111; eval(); tag = "";
    // R7 second sleeper refused; R9 register 0 reads zero
    step_begin(); rd0_en = 1; rd0_addr = 3; rd0_pc = 16'h0222;
    rd1_en = 1; rd1_addr = 0; eval();
    // R4 write releases; R8 same-cycle write forwarded to the read
    step_begin(); wr_en = 1; wr_addr = 3; wr_data = 32'hDEAD_BEEF;
    tag = "R8"; rd0_en = 1; rd0_addr = 3; eval(); tag = "";
    step_begin(); rd1_en = 1; rd1_addr = 3; eval();
    // R8 both ports on one empty register
    step_begin(); tag = "R8"; rd0_en = 1; rd1_en = 1; rd0_addr = 7; rd1_addr = 7;
    rd0_pc = 16'h0777; rd1_pc = 16'h0888; eval(); tag = "";
    // R5 set releases on lane 1; R9 write to register 0 ignored
    step_begin(); sig_en = 1; sig_addr = 7; wr_en = 1; wr_addr = 0; wr_data = 32'h5; eval();
    step_begin(); rd0_en = 1; rd0_addr = 0; rd1_en = 1; rd1_addr = 7; eval();
    // R10 clear in the same cycle as a park drops it; R6 no wake
    step_begin(); tag = "R10"; rd0_en = 1; rd0_addr = 9; rd0_pc = 16'h0999;
    clr_en = 1; clr_addr = 9; eval(); tag = "";
    step_begin(); tag = "R6"; rd0_en = 1; rd0_addr = 9; rd0_pc = 16'h0aaa; eval(); tag = "";
    step_begin(); tag = "R6"; clr_en = 1; clr_addr = 9; eval();
    step_begin(); wr_en = 1; wr_addr = 9; wr_data = 32'h1; eval(); tag = "";
    // R5 set ignored when the same register is written
    step_begin(); rd0_en = 1; rd0_addr = 12; rd0_pc = 16'h0c0c; eval();
    step_begin(); tag = "R5"; wr_en = 1; wr_addr = 12; wr_data = 32'h1234;
    sig_en = 1; sig_addr = 12; eval();
    step_begin(); rd0_en = 1; rd0_addr = 12; eval(); tag = "";
    // R10 clear-all together with a releasing write
    step_begin(); rd0_en = 1; rd0_addr = 4; rd0_pc = 16'h0444; eval();
    step_begin(); tag = "R10"; wr_en = 1; wr_addr = 4; wr_data = 32'h44; clr_all = 1; eval();
    step_begin(); rd0_en = 1; rd0_addr = 4; rd0_pc = 16'h0445; eval(); tag = "";

    // random phase over a small address window
    for (int n = 0; n < 4000; n++) begin
      step_begin();
      rd0_en = ($urandom_range(0, 9) < 7);
      rd1_en = ($urandom_range(0, 9) < 5);
      rd0_addr = AW'($urandom_range(0, 7));
      rd1_addr = AW'($urandom_range(0, 7));
      rd0_pc = PCW'($urandom); rd1_pc = PCW'($urandom);
      wr_en = ($urandom_range(0, 2) == 0);
      wr_addr = AW'($urandom_range(0, 7)); wr_data = $urandom;
      sig_en = ($urandom_range(0, 5) == 0);
      sig_addr = AW'($urandom_range(0, 7));
      clr_en = ($urandom_range(0, 7) == 0);
      clr_addr = AW'($urandom_range(0, 7));
      clr_all = ($urandom_range(0, 63) == 0);
      eval();
    end
    step_begin(); eval();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule